// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. The command logic gives it a start column, a burst length code, an ordering bit and a one-cycle start pulse. From the next cycle on, the block puts out one column per clock with a valid flag, and it raises a last-beat flag on the final beat of a bounded burst.

Bounded bursts of 2, 4 or 8 beats wrap inside the aligned block that holds the start column. The order is either linear (count up modulo the length) or interleaved (the beat index XORed into the low bits). A full-page burst counts through every column, rolls over from the top column to zero, and runs until a stop pulse arrives. A stop pulse ends the burst at once. So does a new start pulse, which also begins the next burst. When the settings are not supported, the block raises an error flag and runs a single-beat burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `busy`, `last` and `cfg_err` are low.
- R2: In the cycle after `start` is sampled high, `busy` is high and `col` equals the sampled `start_col`.
- R3: `len_sel` sets the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page.
- R4: When `ilv` is 0 in a bounded burst, beat i drives the low log2(BL) bits to (start + i) mod BL, and the upper bits stay equal to those of the start column.
- R5: When `ilv` is 1 in a bounded burst, beat i drives the low log2(BL) bits to start XOR i, and the upper bits stay equal to those of the start column.
- R6: `last` is high on beat BL-1 only. In the cycle after that beat, `busy` is low unless a new start was sampled.
- R7: A full-page burst (`len_sel` 3'b111, `ilv` 0) drives (start + i) mod 256 on beat i, wraps from 255 to 0, never raises `last`, and stays busy until it is stopped.
- R8: When `stop` is sampled high and `start` is low, `busy` is low in the next cycle.
- R9: When `start` is sampled during a burst, the next cycle shows beat 0 of the new burst.
- R10: Codes 3'b100 to 3'b110, and code 3'b111 with `ilv` 1, give a single-beat burst at the start column with `cfg_err` and `last` high.
- R11: `cfg_err` is low during every burst whose settings are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the current settings |
| stop | input | 1 | End the current burst |
| start_col | input | COL_W | First column of the burst |
| len_sel | input | 3 | Burst length code |
| ilv | input | 1 | Ordering: 0 linear, 1 interleaved |
| col | output | COL_W | Column address of the current beat |
| busy | output | 1 | A beat is being driven this cycle |
| last | output | 1 | Final beat of a bounded burst |
| cfg_err | output | 1 | The current burst came from settings that are not supported |

## Verification
The bench runs every start column through lengths 2, 4 and 8 in both orders and compares each beat against a model. A design that carries into the upper bits, or that mixes up add and XOR, fails on unaligned starts such as 5, 6 and 7. A full-page run that crosses column 255 catches a counter that saturates or stops there, and it also catches a stray `last` pulse. Stop and restart are applied in the middle of a burst, which exposes a design that lets the old burst run on. Each reserved code is tried to confirm that the block falls back to one beat with the error flag set, and does not hang or run a long burst.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv,
  output logic [COL_W-1:0] col,
  output logic             busy,
  output logic             last,
  output logic             cfg_err
);
  localparam logic [COL_W-1:0] ALL1 = {COL_W{1'b1}};

  logic             busy_q, full_q, ilv_q, err_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d, err_d;

  always_comb begin
    mask_d = '0;
    full_d = 1'b0;
    err_d  = 1'b0;
    case (len_sel)
      3'b000: mask_d = '0;
      3'b001: mask_d = COL_W'(1);
      3'b010: mask_d = COL_W'(3);
      3'b011: mask_d = COL_W'(7);
      3'b111: begin
        if (ilv) err_d = 1'b1;
        else begin
          mask_d = ALL1;
          full_d = 1'b1;
        end
      end
      default: err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      full_q <= full_d;
      ilv_q  <= ilv & ~err_d;
      err_q  <= err_d;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_d;
    end else if (stop || last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  wire [COL_W-1:0] low_seq = (base_q + beat_q) & mask_q;
  wire [COL_W-1:0] low_ilv = (base_q ^ beat_q) & mask_q;

  assign col     = (base_q & ~mask_q) | (ilv_q ? low_ilv : low_seq);
  assign busy    = busy_q;
  assign last    = busy_q & ~full_q & (beat_q == mask_q);
  assign cfg_err = busy_q & err_q;

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && col == $past(start_col));

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && !stop && !last |=> busy && ((col & ~mask_q) == ($past(col) & ~mask_q)));

  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> !busy);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !busy);

  // R10
  bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && len_sel[2] && (len_sel != 3'b111 || ilv) |=> cfg_err && last && col == $past(start_col));

  // R7
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && len_sel == 3'b111 && !ilv |=> busy && !last && !cfg_err);
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, ilv = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic [7:0] col;
  logic       busy, last, cfg_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .start_col(start_col),
    .len_sel(len_sel), .ilv(ilv), .col(col), .busy(busy), .last(last), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] s, input int i, input int bl, input bit iv);
    logic [7:0] m = 8'(bl - 1);
    logic [7:0] lo = iv ? ((s ^ 8'(i)) & m) : ((s + 8'(i)) & m);
    return (s & ~m) | lo;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic kick(input logic [7:0] s, input logic [2:0] code, input bit iv);
    start_col = s; len_sel = code; ilv = iv; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(!busy && !last && !cfg_err, "R1 reset idle", {busy, last, cfg_err}, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_bounded(input logic [2:0] code, input int bl, input bit iv, input logic [7:0] s);
    kick(s, code, iv);
    for (int i = 0; i < bl; i++) begin
      chk(busy, "R2 busy during burst", busy, 1);
      chk(col == model(s, i, bl, iv), iv ? "R5 interleaved col" : "R4 sequential col", col, model(s, i, bl, iv));
      chk(last == (i == bl - 1), "R6 last on final beat", last, i == bl - 1);
      chk(!cfg_err, "R11 no error on valid burst", cfg_err, 0);
      step();
    end
    chk(!busy, "R3 burst length honoured", busy, 0);
  endtask

  task automatic t_sweep();
    for (int k = 1; k <= 3; k++)
      for (int iv = 0; iv < 2; iv++)
        for (int s = 0; s < 256; s++)
          t_bounded(3'(k), 1 << k, iv[0], 8'(s));
    t_bounded(3'b000, 1, 1'b0, 8'd77);
    t_bounded(3'b000, 1, 1'b1, 8'd200);
  endtask

  task automatic t_full();
    kick(8'd250, 3'b111, 1'b0);
    for (int i = 0; i < 300; i++) begin
      chk(busy && !last && !cfg_err, "R7 full page busy, no last", {busy, last, cfg_err}, 4);
      chk(col == 8'(250 + i), "R7 full page col wraps", col, (250 + i) % 256);
      step();
    end
    stop = 1'b1; step(); stop = 1'b0;
    chk(!busy, "R8 stop ends full page", busy, 0);
  endtask

  task automatic t_stop_mid();
    kick(8'd18, 3'b011, 1'b0);
    step();
    chk(col == 8'd19, "R4 second beat", col, 19);
    stop = 1'b1; step(); stop = 1'b0;
    chk(!busy && !last, "R8 stop ends bounded burst", {busy, last}, 0);
  endtask

  task automatic t_restart();
    kick(8'd0, 3'b011, 1'b0);
    step(); step();
    chk(col == 8'd2, "R9 pre-restart beat", col, 2);
    kick(8'h45, 3'b010, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk(busy && col == (8'h45 ^ 8'(i)), "R9 restart interleaved", col, 8'h45 ^ 8'(i));
      chk(last == (i == 3), "R9 restart last", last, i == 3);
      step();
    end
    chk(!busy, "R9 restarted burst ends", busy, 0);
  endtask

  task automatic t_reserved();
    for (int c = 4; c < 8; c++) begin
      kick(8'(c * 9), 3'(c), c == 7);
      chk(busy && cfg_err && last, "R10 reserved flags", {busy, cfg_err, last}, 7);
      chk(col == 8'(c * 9), "R10 reserved col", col, c * 9);
      step();
      chk(!busy && !cfg_err, "R10 reserved single beat", {busy, cfg_err}, 0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_full();
    t_stop_mid();
    t_restart();
    t_reserved();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule